// File: doc/BRIEF.md
# Horizontal Sync Detector with Free-Wheel

This block looks at low-pass-filtered luma samples, one per clock, and works out where the horizontal sync pulses are. A sample counts as low when its level is below a programmable threshold. A sync is detected only after a programmable number of consecutive low samples, so short dips are not reported as sync. A line-position counter runs at the programmed nominal line length. Each detected sync that falls near the expected line start pulls the counter into phase.

The block puts out a one-cycle hsync strobe on every line boundary. When sync goes away, it keeps putting out strobes at the nominal line period (free-wheel). Free-wheel can be switched off. Downstream loss-of-video logic then sees the missing pulses directly. A lock flag shows stable tracking over many lines. A presence flag shows whether any sync has been accepted recently.

Each line is judged once, when its tracking window closes. The line is a hit if a sync was accepted during it, and a miss otherwise. The lock flag and the reacquisition mode are both driven by runs of hits and misses.

Top module: `hsync_freewheel_det`

## Requirements
- R1: A sample is low when `samp < cfg_thresh`. A sync is detected in the cycle of the `cfg_min_run`-th consecutive low sample, once per low run. A value of 0 is treated as 1. Low runs shorter than `cfg_min_run` are never detected.
- R2: With no accepted sync, `hsync` is a one-cycle strobe that repeats every `cfg_line_len` cycles. After reset, the first strobe comes in the cycle WIN+1 cycles after reset is released.
- R3: An accepted sync retimes the line. The next `hsync` comes exactly WIN+1 cycles after the cycle in which the sync was accepted, and later strobes follow every `cfg_line_len` cycles.
- R4: While tracking, a sync is accepted only if it lies within WIN samples, early or late, of the expected line start. A sync outside that window has no effect on the `hsync` timing.
- R5: After MISS_LIMIT consecutive missed lines, the next detected sync is accepted at any position. The block leaves reset in this acquisition state.
- R6: With `cfg_fw_en` low, `hsync` is given only for lines in which a sync was accepted. With no sync present, no strobe appears.
- R7: `locked` rises after LOCK_COUNT consecutive hit lines. It falls after LOCK_COUNT consecutive missed lines.
- R8: `sync_present` is high for PRESENT_LINES × `cfg_line_len` cycles after each accepted sync, and low otherwise.
- R9: During reset, `hsync`, `locked` and `sync_present` are all low.

`cfg_line_len` must exceed 2×WIN+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| samp | input | SAMPLE_W | Filtered luma sample |
| cfg_thresh | input | SAMPLE_W | Low-level threshold |
| cfg_min_run | input | RUN_W | Consecutive low samples needed for a sync |
| cfg_line_len | input | LINE_W | Nominal line length in samples |
| cfg_fw_en | input | 1 | Free-wheel enable |
| hsync | output | 1 | One-cycle line strobe |
| sync_present | output | 1 | A sync was accepted within the last PRESENT_LINES lines |
| locked | output | 1 | Line tracking is stable |

## Verification
The assertions run on every cycle and check four kinds of rule. Strobes fall only on window closes. With free-wheel off, a strobe needs a hit line. Outside acquisition, an accepted sync must lie in the window; every accepted sync restarts the line counter at position 1 and raises the presence flag on the next cycle. A detection needs a preceding low sample, and the lock flag can rise only at a window close.

Some properties are visible only in the bench's scenarios:
- that glitches shorter than the run length leave the phase alone;
- that jittered lines stay locked;
- that a displaced pulse is ignored;
- that a sync at a new phase is taken once enough lines have been missed;
- the exact strobe counts over silent stretches with free-wheel on and off.

The behavioural model checks all of these against the outputs on every cycle.

// File: rtl/hsd_pkg.sv
package hsd_pkg;

  // Verdict on one line, produced when its tracking window closes
  typedef enum logic [1:0] {
    LV_IDLE = 2'd0,
    LV_HIT  = 2'd1,
    LV_MISS = 2'd2
  } line_verdict_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/hsd_run_detect.sv
module hsd_run_detect #(
  parameter int SAMPLE_W = 10,
  parameter int RUN_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] samp,
  input  logic [SAMPLE_W-1:0] thresh,
  input  logic [RUN_W-1:0]    min_run,
  output logic                det
);

  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  logic [RUN_W-1:0] run_q;
  logic             low;

  // Count of prior low samples needed so the current one completes the run
  function automatic logic [RUN_W-1:0] prior_needed(input logic [RUN_W-1:0] m);
    return (m == '0) ? '0 : m - RUN_W'(1);
  endfunction

  assign low = (samp < thresh);
  assign det = low && (run_q == prior_needed(min_run));

  always_ff @(posedge clk) begin
    if (!rst_n)          run_q <= '0;
    else if (!low)       run_q <= '0;
    else if (run_q != RUN_MAX) run_q <= run_q + RUN_W'(1);
  end

endmodule

// File: rtl/hsd_line_timer.sv
module hsd_line_timer #(
  parameter int LINE_W = 12,
  parameter int WIN    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] len,
  input  logic              accept,
  output logic [LINE_W-1:0] pos,
  output logic              in_win,
  output logic              close
);

  localparam logic [LINE_W-1:0] WIN_L     = LINE_W'(WIN);
  localparam logic [LINE_W-1:0] CLOSE_POS = LINE_W'(WIN + 1);

  function automatic logic window_hit(input logic [LINE_W-1:0] p,
                                      input logic [LINE_W-1:0] l);
    return (p <= WIN_L) || (p >= l - WIN_L);
  endfunction

  function automatic logic [LINE_W-1:0] next_pos(input logic [LINE_W-1:0] p,
                                                 input logic [LINE_W-1:0] l,
                                                 input logic acc);
    if (acc)                   return LINE_W'(1);
    if (p >= l - LINE_W'(1))   return '0;
    return p + LINE_W'(1);
  endfunction

  assign in_win = window_hit(pos, len);
  assign close  = (pos == CLOSE_POS);

  always_ff @(posedge clk) begin
    if (!rst_n) pos <= '0;
    else        pos <= next_pos(pos, len, accept);
  end

endmodule

// File: rtl/hsd_lock_track.sv
module hsd_lock_track
  import hsd_pkg::*;
#(
  parameter int LINE_W        = 12,
  parameter int MISS_LIMIT    = 3,
  parameter int LOCK_COUNT    = 8,
  parameter int PRESENT_LINES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] len,
  input  logic              accept,
  input  logic              close,
  output logic              hit_q,
  output logic              acquire,
  output logic              locked,
  output logic              sync_present
);

  localparam int MISS_SAT = max_int(MISS_LIMIT, LOCK_COUNT);
  localparam int MISS_W   = $clog2(MISS_SAT + 1);
  localparam int HIT_W    = $clog2(LOCK_COUNT + 1);
  localparam int SIL_W    = LINE_W + $clog2(PRESENT_LINES) + 1;

  localparam logic [MISS_W-1:0] MISS_MAX  = MISS_W'(MISS_SAT);
  localparam logic [MISS_W-1:0] MISS_ACQ  = MISS_W'(MISS_LIMIT);
  localparam logic [MISS_W-1:0] MISS_DROP = MISS_W'(LOCK_COUNT);
  localparam logic [HIT_W-1:0]  HIT_MAX   = HIT_W'(LOCK_COUNT);
  localparam logic [SIL_W-1:0]  SIL_MAX   = '1;

  logic [MISS_W-1:0] miss_q, miss_n;
  logic [HIT_W-1:0]  hitrun_q, hitrun_n;
  logic [SIL_W-1:0]  sil_q, sil_n;
  logic              hit_n, lock_n, pres_n;
  line_verdict_e     verdict;

  function automatic logic [SIL_W-1:0] silence_limit(input logic [LINE_W-1:0] l);
    return SIL_W'(l) * SIL_W'(PRESENT_LINES);
  endfunction

  assign acquire = (miss_q >= MISS_ACQ);

  always_comb begin
    verdict = LV_IDLE;
    if (close) verdict = hit_q ? LV_HIT : LV_MISS;

    miss_n   = miss_q;
    hitrun_n = hitrun_q;
    lock_n   = locked;
    case (verdict)
      LV_HIT: begin
        miss_n = '0;
        if (hitrun_q != HIT_MAX) hitrun_n = hitrun_q + HIT_W'(1);
        if (hitrun_n == HIT_MAX) lock_n = 1'b1;
      end
      LV_MISS: begin
        hitrun_n = '0;
        if (miss_q != MISS_MAX) miss_n = miss_q + MISS_W'(1);
        if (miss_n >= MISS_DROP) lock_n = 1'b0;
      end
      default: ;
    endcase

    hit_n  = accept ? 1'b1 : (close ? 1'b0 : hit_q);
    sil_n  = accept ? '0 : ((sil_q == SIL_MAX) ? sil_q : sil_q + SIL_W'(1));
    pres_n = accept ? 1'b1 : ((sil_n >= silence_limit(len)) ? 1'b0 : sync_present);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      miss_q       <= MISS_MAX;
      hitrun_q     <= '0;
      hit_q        <= 1'b0;
      locked       <= 1'b0;
      sil_q        <= SIL_MAX;
      sync_present <= 1'b0;
    end else begin
      miss_q       <= miss_n;
      hitrun_q     <= hitrun_n;
      hit_q        <= hit_n;
      locked       <= lock_n;
      sil_q        <= sil_n;
      sync_present <= pres_n;
    end
  end

endmodule

// File: rtl/hsync_freewheel_det.sv
module hsync_freewheel_det #(
  parameter int SAMPLE_W      = 10,
  parameter int RUN_W         = 6,
  parameter int LINE_W        = 12,
  parameter int WIN           = 4,
  parameter int MISS_LIMIT    = 3,
  parameter int LOCK_COUNT    = 8,
  parameter int PRESENT_LINES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] samp,
  input  logic [SAMPLE_W-1:0] cfg_thresh,
  input  logic [RUN_W-1:0]    cfg_min_run,
  input  logic [LINE_W-1:0]   cfg_line_len,
  input  logic                cfg_fw_en,
  output logic                hsync,
  output logic                sync_present,
  output logic                locked
);

  // Internal events, named for the checker
  logic              sync_det;
  logic              sync_accept;
  logic              in_window;
  logic              line_close;
  logic              line_hit;
  logic              acquire;
  logic [LINE_W-1:0] line_pos;

  hsd_run_detect #(.SAMPLE_W(SAMPLE_W), .RUN_W(RUN_W)) u_run (
    .clk    (clk),
    .rst_n  (rst_n),
    .samp   (samp),
    .thresh (cfg_thresh),
    .min_run(cfg_min_run),
    .det    (sync_det)
  );

  assign sync_accept = sync_det && (in_window || acquire);

  hsd_line_timer #(.LINE_W(LINE_W), .WIN(WIN)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .len   (cfg_line_len),
    .accept(sync_accept),
    .pos   (line_pos),
    .in_win(in_window),
    .close (line_close)
  );

  hsd_lock_track #(
    .LINE_W(LINE_W), .MISS_LIMIT(MISS_LIMIT),
    .LOCK_COUNT(LOCK_COUNT), .PRESENT_LINES(PRESENT_LINES)
  ) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .len         (cfg_line_len),
    .accept      (sync_accept),
    .close       (line_close),
    .hit_q       (line_hit),
    .acquire     (acquire),
    .locked      (locked),
    .sync_present(sync_present)
  );

  assign hsync = line_close && (cfg_fw_en || line_hit);

endmodule

// File: rtl/hsd_checker.sv
module hsd_checker #(
  parameter int SAMPLE_W = 10,
  parameter int RUN_W    = 6,
  parameter int LINE_W   = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic [SAMPLE_W-1:0] samp,
  input logic [SAMPLE_W-1:0] cfg_thresh,
  input logic [RUN_W-1:0]    cfg_min_run,
  input logic                cfg_fw_en,
  input logic                hsync,
  input logic                sync_present,
  input logic                locked,
  input logic                sync_det,
  input logic                sync_accept,
  input logic                acquire,
  input logic                in_window,
  input logic                line_close,
  input logic                line_hit,
  input logic [LINE_W-1:0]   line_pos
);

  assert_run_needs_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_det && cfg_min_run >= RUN_W'(2)) |-> $past(samp < cfg_thresh));

  assert_strobe_on_close_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |-> line_close);

  assert_accept_retimes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sync_accept |=> (line_pos == LINE_W'(1)));

  assert_window_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_accept && !acquire) |-> in_window);

  assert_no_freewheel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync && !cfg_fw_en) |-> line_hit);

  assert_lock_at_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(line_close));

  assert_present_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sync_accept |=> sync_present);

endmodule

bind hsync_freewheel_det hsd_checker #(
  .SAMPLE_W(SAMPLE_W), .RUN_W(RUN_W), .LINE_W(LINE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .samp(samp), .cfg_thresh(cfg_thresh),
  .cfg_min_run(cfg_min_run), .cfg_fw_en(cfg_fw_en), .hsync(hsync),
  .sync_present(sync_present), .locked(locked), .sync_det(sync_det),
  .sync_accept(sync_accept), .acquire(acquire), .in_window(in_window),
  .line_close(line_close), .line_hit(line_hit), .line_pos(line_pos)
);

// File: tb/hsync_freewheel_det_tb_top.sv
module hsync_freewheel_det_tb_top;

  localparam int SW = 10, RW = 6, LW = 12;
  localparam int WIN = 4, ML = 3, LC = 8, PL = 4;
  localparam int MSAT = (ML > LC) ? ML : LC;
  localparam int HI = 200, LO = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [SW-1:0] samp;
  logic [SW-1:0] cfg_thresh;
  logic [RW-1:0] cfg_min_run;
  logic [LW-1:0] cfg_line_len;
  logic          cfg_fw_en;
  logic          hsync, sync_present, locked;

  always #5 clk = ~clk;

  hsync_freewheel_det #(
    .SAMPLE_W(SW), .RUN_W(RW), .LINE_W(LW), .WIN(WIN),
    .MISS_LIMIT(ML), .LOCK_COUNT(LC), .PRESENT_LINES(PL)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .samp(samp), .cfg_thresh(cfg_thresh),
    .cfg_min_run(cfg_min_run), .cfg_line_len(cfg_line_len),
    .cfg_fw_en(cfg_fw_en), .hsync(hsync), .sync_present(sync_present),
    .locked(locked)
  );

  int    checks = 0, failures = 0, hs_cnt = 0;
  string req = "R9";

  // Behavioural model state: plain integers
  int m_pos, m_hit, m_miss, m_hitrun, m_locked, m_sil, m_present, m_run;

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_pos = 0; m_hit = 0; m_miss = MSAT; m_hitrun = 0;
    m_locked = 0; m_sil = 1000000; m_present = 0; m_run = 0;
  endtask

  task automatic model_step();
    int len, lo, need, det, inw, acc, cls;
    len  = int'(cfg_line_len);
    lo   = (int'(samp) < int'(cfg_thresh)) ? 1 : 0;
    need = (cfg_min_run == 0) ? 1 : int'(cfg_min_run);
    det  = (lo != 0 && m_run == need - 1) ? 1 : 0;
    inw  = (m_pos <= WIN || m_pos >= len - WIN) ? 1 : 0;
    acc  = (det != 0 && (inw != 0 || m_miss >= ML)) ? 1 : 0;
    cls  = (m_pos == WIN + 1) ? 1 : 0;
    if (cls != 0) begin
      if (m_hit != 0) begin
        m_miss = 0;
        if (m_hitrun < LC) m_hitrun++;
        if (m_hitrun >= LC) m_locked = 1;
      end else begin
        m_hitrun = 0;
        if (m_miss < MSAT) m_miss++;
        if (m_miss >= LC) m_locked = 0;
      end
    end
    if (acc != 0) m_hit = 1;
    else if (cls != 0) m_hit = 0;
    m_run = (lo != 0) ? m_run + 1 : 0;
    m_pos = (acc != 0) ? 1 : ((m_pos >= len - 1) ? 0 : m_pos + 1);
    if (acc != 0) begin
      m_sil = 0; m_present = 1;
    end else begin
      m_sil++;
      if (m_sil >= PL * len) m_present = 0;
    end
  endtask

  // One sample: drive, settle, compare to model, advance model, wait
  task automatic cyc(int s);
    int exp_hs;
    samp = SW'(s);
    #1;
    exp_hs = (m_pos == WIN + 1 && (cfg_fw_en || m_hit != 0)) ? 1 : 0;
    check("hsync", int'(hsync), exp_hs);
    check("sync_present", int'(sync_present), m_present);
    check("locked", int'(locked), m_locked);
    if (hsync) hs_cnt++;
    model_step();
    @(negedge clk);
  endtask

  task automatic line(int period, int at, int width, int g_at, int g_w);
    for (int i = 0; i < period; i++) begin
      int s;
      s = HI;
      if (i >= at && i < at + width) s = LO;
      if (i >= g_at && i < g_at + g_w) s = LO;
      cyc(s);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R9 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int h0;
    rst_n = 1'b0; samp = SW'(HI); cfg_thresh = SW'(100);
    cfg_min_run = RW'(5); cfg_line_len = LW'(64); cfg_fw_en = 1'b1;
    model_reset();
    repeat (3) @(negedge clk);
    #1;
    req = "R9";
    check("reset hsync", int'(hsync), 0);
    check("reset locked", int'(locked), 0);
    check("reset sync_present", int'(sync_present), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Free-running period from reset
    req = "R2"; h0 = hs_cnt;
    repeat (3) line(64, 0, 0, -1, 0);
    check("free-run strobes in 3 lines", hs_cnt - h0, 3);

    // Acquire and track a clean sync train
    req = "R3";
    repeat (20) line(64, 10, 8, -1, 0);
    req = "R7"; check("locked after clean lines", int'(locked), 1);
    req = "R8"; check("present after clean lines", int'(sync_present), 1);

    // Jittered lines inside the window
    req = "R4";
    repeat (3) begin line(62, 0, 8, -1, 0); line(66, 0, 8, -1, 0); end
    check("locked under jitter", int'(locked), 1);
    h0 = hs_cnt;
    line(64, 30, 8, -1, 0);
    check("one strobe with displaced pulse", hs_cnt - h0, 1);
    repeat (4) line(64, 0, 8, -1, 0);
    check("locked after displaced pulse", int'(locked), 1);

    // Short glitches between syncs
    req = "R1";
    repeat (6) line(64, 0, 8, 30, 4);
    check("locked with short glitches", int'(locked), 1);

    // Sync removed, free-wheel on
    req = "R2"; h0 = hs_cnt;
    repeat (10) line(64, 0, 0, -1, 0);
    check("free-wheel strobes in 10 lines", hs_cnt - h0, 10);
    req = "R8"; check("present after silence", int'(sync_present), 0);
    req = "R7"; check("lock lost after silence", int'(locked), 0);

    // Sync returns at a new phase
    req = "R5";
    repeat (10) line(64, 37, 8, -1, 0);
    check("relocked at new phase", int'(locked), 1);

    // Free-wheel off
    req = "R6"; cfg_fw_en = 1'b0; h0 = hs_cnt;
    repeat (5) line(64, 0, 0, -1, 0);
    check("no strobes without sync", hs_cnt - h0, 0);
    h0 = hs_cnt;
    repeat (5) line(64, 37, 8, -1, 0);
    check("strobes return with sync", (hs_cnt - h0 > 0) ? 1 : 0, 1);

    // Run length of zero acts as one; runs one short never detect
    req = "R1"; cfg_fw_en = 1'b1; cfg_min_run = RW'(0);
    repeat (10) line(64, 37, 1, -1, 0);
    check("single-sample sync with zero run", int'(locked), 1);
    cfg_min_run = RW'(5);
    repeat (10) line(64, 37, 4, -1, 0);
    check("short runs never detect", int'(locked), 0);
    check("short runs clear present", int'(sync_present), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule